// File: doc/BRIEF.md
# Bit-Banged MDIO Management Responder

This block answers clause-22 style management frames that a host produces by software, one bit at a time. The host toggles a clock pin and either drives the shared data pin or releases it. The block detects each low-to-high transition of the clock pin and treats it as one bit time. On that bit time it takes the data bit from the host, or keeps the bit it last presented when the host has let go. It then steps a frame decoder through start, opcode, PHY address, register address, turnaround and data.

Writes land in an array of 16-bit registers indexed by PHY address and register address. Reads fetch a word and shift it out MSB first on the data-out bit. While the host is not driving, the data pin reflects that bit. A few register numbers return fixed identity and capability words. The control register at number 0 has some bits masked and one bit forced on readback. The block is meant for emulation or test platforms in which a processor bit-bangs a management bus through general-purpose pins.

Top module: `mdio_bitbang_resp`

## Requirements
- R1: The decoder advances exactly once per low-to-high transition of the clock pin. Holding the clock pin high for several cycles, or changing the data input while it stays high, has no further effect.
- R2: A data bit is taken from the data input only when the direction input shows the host driving. On a bit time with the host released, the bit last on the line is reused as the received bit, and data-out does not change outside the read data phase.
- R3: While idle, a 1 bit keeps the decoder idle and a 0 bit enters the start phase. The following bit must be 1. A 0 discards the frame, and the bit after the discard is decoded as if from idle, so a 0 there begins a new frame.
- R4: The two opcode bits 1 then 0 select a read, and 0 then 1 select a write. The pairs 1,1 and 0,0 abort to the reset state and write nothing.
- R5: After the opcode, 5 PHY address bits and then 5 register address bits are received, each field MSB first.
- R6: A write frame has two turnaround bit times before its data. A read frame has one, and the first data bit is presented on the bit time that follows it.
- R7: Each frame carries 16 data bits, MSB first. A write stores the word after its 16th data bit and the decoder returns to reset. A read presents the fetched word bit by bit.
- R8: Register number 0 reads back its stored value with bits 15 and 9 cleared and bit 13 set.
- R9: Register numbers 1, 2, 3, 5, 6 and 17 always read 0x782C, 0x0013, 0x61D4, 0x41E1, 0x0001 and 0x4700 respectively, whatever has been written to them.
- R10: All other registers are plain storage, separate for each of the 32 PHY addresses and 32 register numbers.
- R11: Data-out always shows the current line bit. After a read data bit time it holds that data bit until the next bit time, and after the last bit it keeps that bit.
- R12: A synchronous reset returns the decoder to its reset state, clears every stored register to 0 and sets data-out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock sampling the pins |
| rst | input | 1 | Synchronous reset, active high |
| mgmt_clk_pin | input | 1 | Host-toggled management clock pin level |
| host_drives | input | 1 | 1 when the host drives the data pin |
| mdio_in | input | 1 | Data pin value driven by the host |
| mdio_out | output | 1 | Line bit presented by the block |

## Verification
Writes and readbacks are run with data words of mixed bit patterns at asymmetric PHY and register addresses. They show that the addresses are routed per PHY and that bits are not reversed. Reads of the fixed-value registers and of register 0 after all-ones and all-zeros writes tell apart plain storage, masking and constants. Frames with a bad start bit or an illegal opcode, each followed by a long run of ones, separate a correct abort from a decoder that takes the ones as a frame. A write sent with long clock-high phases and data that toggles mid-phase catches level-sensitive stepping. A write with released bit times shows whether the held line bit is used.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_IDLE,
      ST_START,
      ST_OPC,
      ST_OPC_RD,
      ST_OPC_WR,
      ST_PHY,
      ST_REG,
      ST_TA,
      ST_DATA
   } mdio_state_e;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } mdio_op_e;

endpackage

// File: rtl/mdio_edge_det.sv
module mdio_edge_det #(
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic pin,
   output logic strobe
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= RESET_LEVEL;
      else     prev_q <= pin;
   end

   assign strobe = pin & ~prev_q;

endmodule

// File: rtl/mdio_reg_array.sv
module mdio_reg_array #(
   parameter int PHY_AW    = 5,
   parameter int REG_AW    = 5,
   parameter int DW        = 16,
   parameter bit FIXED_IDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_word,
   output logic [DW-1:0]     rd_word
);

   localparam int IW    = PHY_AW + REG_AW;
   localparam int DEPTH = 1 << IW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] raw;
   logic [IW-1:0] idx;

   assign idx = {phy_addr, reg_addr};
   assign raw = mem[idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[idx] <= wr_word;
      end
   end

   generate
      if (FIXED_IDS) begin : g_fixed
         always_comb begin
            unique case (reg_addr)
               REG_AW'(0):  rd_word = (raw & ~DW'(16'h8200)) | DW'(16'h2000);
               REG_AW'(1):  rd_word = DW'(16'h782C);
               REG_AW'(2):  rd_word = DW'(16'h0013);
               REG_AW'(3):  rd_word = DW'(16'h61D4);
               REG_AW'(5):  rd_word = DW'(16'h41E1);
               REG_AW'(6):  rd_word = DW'(16'h0001);
               REG_AW'(17): rd_word = DW'(16'h4700);
               default:     rd_word = raw;
            endcase
         end
      end else begin : g_plain
         assign rd_word = raw;
      end
   endgenerate

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_resp_pkg::*;
#(
   parameter int PHY_AW = 5,
   parameter int REG_AW = 5,
   parameter int DW     = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic              host_drv,
   input  logic              din,
   input  logic [DW-1:0]     rd_word,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [REG_AW-1:0] reg_addr,
   output logic              wr_en,
   output logic [DW-1:0]     wr_word,
   output logic              line_bit,
   output mdio_state_e       state
);

   localparam int AMAX = (PHY_AW > REG_AW) ? PHY_AW : REG_AW;
   localparam int CW   = $clog2(AMAX + 1);
   localparam int PW   = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [PW-1:0] POS_TOP = PW'(DW - 1);

   mdio_state_e       st_q,   st_n;
   mdio_op_e          op_q,   op_n;
   logic [PHY_AW-1:0] phy_q,  phy_n;
   logic [REG_AW-1:0] reg_q,  reg_n;
   logic [DW-1:0]     data_q, data_n;
   logic [PW-1:0]     pos_q,  pos_n;
   logic [CW-1:0]     cnt_q,  cnt_n;
   logic              ta_q,   ta_n;
   logic              line_q, line_n;
   logic              cap;
   logic [DW-1:0]     word;

   assign cap  = host_drv ? din : line_q;
   assign word = (op_q == OP_READ && pos_q == POS_TOP) ? rd_word : data_q;

   always_comb begin
      st_n    = st_q;
      op_n    = op_q;
      phy_n   = phy_q;
      reg_n   = reg_q;
      data_n  = data_q;
      pos_n   = pos_q;
      cnt_n   = cnt_q;
      ta_n    = ta_q;
      line_n  = line_q;
      wr_en   = 1'b0;
      wr_word = data_q;
      if (strobe) begin
         line_n = cap;
         unique case (st_q)
            ST_RESET, ST_IDLE: begin
               if (st_q == ST_RESET) begin
                  phy_n  = '0;
                  reg_n  = '0;
                  data_n = '0;
                  pos_n  = POS_TOP;
               end
               st_n = cap ? ST_IDLE : ST_START;
            end
            ST_START:  st_n = cap ? ST_OPC : ST_RESET;
            ST_OPC:    st_n = cap ? ST_OPC_RD : ST_OPC_WR;
            ST_OPC_RD: begin
               if (!cap) begin
                  op_n  = OP_READ;
                  cnt_n = '0;
                  st_n  = ST_PHY;
               end else begin
                  st_n  = ST_RESET;
               end
            end
            ST_OPC_WR: begin
               if (cap) begin
                  op_n  = OP_WRITE;
                  cnt_n = '0;
                  st_n  = ST_PHY;
               end else begin
                  st_n  = ST_RESET;
               end
            end
            ST_PHY: begin
               phy_n = {phy_q[PHY_AW-2:0], cap};
               if (cnt_q == CW'(PHY_AW - 1)) begin
                  cnt_n = '0;
                  st_n  = ST_REG;
               end else begin
                  cnt_n = cnt_q + 1'b1;
               end
            end
            ST_REG: begin
               reg_n = {reg_q[REG_AW-2:0], cap};
               if (cnt_q == CW'(REG_AW - 1)) begin
                  cnt_n = '0;
                  ta_n  = 1'b0;
                  st_n  = ST_TA;
               end else begin
                  cnt_n = cnt_q + 1'b1;
               end
            end
            ST_TA: begin
               if (op_q == OP_READ || ta_q) st_n = ST_DATA;
               else                         ta_n = 1'b1;
            end
            ST_DATA: begin
               if (op_q == OP_READ) begin
                  line_n = word[pos_q];
                  data_n = word;
               end else begin
                  data_n = data_q | (DW'(cap) << pos_q);
               end
               if (pos_q == '0) begin
                  st_n = ST_RESET;
                  if (op_q == OP_WRITE) begin
                     wr_en   = 1'b1;
                     wr_word = data_n;
                  end
               end else begin
                  pos_n = pos_q - 1'b1;
               end
            end
            default: st_n = ST_RESET;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_RESET;
         op_q   <= OP_READ;
         phy_q  <= '0;
         reg_q  <= '0;
         data_q <= '0;
         pos_q  <= POS_TOP;
         cnt_q  <= '0;
         ta_q   <= 1'b0;
         line_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         op_q   <= op_n;
         phy_q  <= phy_n;
         reg_q  <= reg_n;
         data_q <= data_n;
         pos_q  <= pos_n;
         cnt_q  <= cnt_n;
         ta_q   <= ta_n;
         line_q <= line_n;
      end
   end

   assign phy_addr = phy_q;
   assign reg_addr = reg_q;
   assign line_bit = line_q;
   assign state    = st_q;

endmodule

// File: rtl/mdio_bitbang_resp.sv
module mdio_bitbang_resp
   import mdio_resp_pkg::*;
#(
   parameter int PHY_AW    = 5,
   parameter int REG_AW    = 5,
   parameter int DW        = 16,
   parameter bit FIXED_IDS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mgmt_clk_pin,
   input  logic host_drives,
   input  logic mdio_in,
   output logic mdio_out
);

   generate
      if (PHY_AW < 2 || REG_AW < 2) begin : g_bad_aw
         $error("address fields need at least two bits");
      end
      if (FIXED_IDS && (DW != 16 || REG_AW < 5)) begin : g_bad_ids
         $error("fixed identity words need 16-bit data and 5-bit register numbers");
      end
   endgenerate

   logic              bit_strobe;
   logic [PHY_AW-1:0] phy_addr;
   logic [REG_AW-1:0] reg_addr;
   logic              wr_en;
   logic [DW-1:0]     wr_word;
   logic [DW-1:0]     rd_word;
   mdio_state_e       fsm_state;

   mdio_edge_det #(.RESET_LEVEL(1'b1)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .pin    (mgmt_clk_pin),
      .strobe (bit_strobe)
   );

   mdio_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .strobe   (bit_strobe),
      .host_drv (host_drives),
      .din      (mdio_in),
      .rd_word  (rd_word),
      .phy_addr (phy_addr),
      .reg_addr (reg_addr),
      .wr_en    (wr_en),
      .wr_word  (wr_word),
      .line_bit (mdio_out),
      .state    (fsm_state)
   );

   mdio_reg_array #(
      .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW), .FIXED_IDS(FIXED_IDS)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .phy_addr (phy_addr),
      .reg_addr (reg_addr),
      .wr_en    (wr_en),
      .wr_word  (wr_word),
      .rd_word  (rd_word)
   );

endmodule

// File: rtl/mdio_resp_checker.sv
module mdio_resp_checker
   import mdio_resp_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic        host_drv,
   input logic        din,
   input logic        dout,
   input logic        strobe,
   input logic        wr_en,
   input mdio_state_e st
);

   p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);

   p_quiet_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(dout));

   p_release_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (strobe && !host_drv && st != ST_DATA) |=> $stable(dout));

   p_bad_start_r3: assert property (@(posedge clk) disable iff (rst)
      (st == ST_START && strobe && host_drv && !din) |=> st == ST_RESET);

   p_bad_opc_hi_r4: assert property (@(posedge clk) disable iff (rst)
      (st == ST_OPC_RD && strobe && host_drv && din) |=> st == ST_RESET);

   p_bad_opc_lo_r4: assert property (@(posedge clk) disable iff (rst)
      (st == ST_OPC_WR && strobe && host_drv && !din) |=> st == ST_RESET);

   p_commit_end_r7: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> st == ST_RESET);

endmodule

bind mdio_bitbang_resp mdio_resp_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .host_drv (host_drives),
   .din      (mdio_in),
   .dout     (mdio_out),
   .strobe   (bit_strobe),
   .wr_en    (wr_en),
   .st       (fsm_state)
);

// File: tb/mdio_bitbang_resp_bench.sv
module mdio_bitbang_resp_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pin = 1'b0;
   logic drv = 1'b1;
   logic din = 1'b1;
   logic dout;

   always #10 clk = ~clk;

   mdio_bitbang_resp u_mdio_bitbang_resp (
      .clk          (clk),
      .rst          (rst),
      .mgmt_clk_pin (pin),
      .host_drives  (drv),
      .mdio_in      (din),
      .mdio_out     (dout)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [15:0] m_mem [32][32];
   logic [15:0] exp_val[$];
   string       exp_tag[$];
   event        ev_cap;
   logic [15:0] acc;
   int          nbits = 0;

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic logic [15:0] m_read(input int p, input int r);
      case (r)
         0:  return (m_mem[p][r] & ~16'h8200) | 16'h2000;
         1:  return 16'h782C;
         2:  return 16'h0013;
         3:  return 16'h61D4;
         5:  return 16'h41E1;
         6:  return 16'h0001;
         17: return 16'h4700;
         default: return m_mem[p][r];
      endcase
   endfunction

   // Monitor: assembles read data bits and compares with the scoreboard
   initial begin
      forever begin
         @(ev_cap);
         acc = {acc[14:0], dout};
         nbits++;
         if (nbits == 16) begin
            nbits = 0;
            if (exp_val.size() == 0) begin
               check(1'b0, "scoreboard underflow", acc, 16'h0);
            end else begin
               check(acc == exp_val[0], exp_tag[0], acc, exp_val[0]);
               void'(exp_val.pop_front());
               void'(exp_tag.pop_front());
            end
         end
      end
   end

   task automatic send_bit(input logic d, input logic b, input bit cap, input int hold, input bit flip);
      @(negedge clk);
      drv = d; din = b; pin = 1'b1;
      @(negedge clk);
      if (cap) ->ev_cap;
      for (int k = 1; k < hold; k++) begin
         if (flip) din = ~b;
         @(negedge clk);
      end
      pin = 1'b0;
   endtask

   task automatic send_field(input int v, input int n, input int hold, input bit flip);
      for (int i = n - 1; i >= 0; i--) send_bit(1'b1, v[i], 1'b0, hold, flip);
   endtask

   task automatic preamble();
      for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b1, 1'b0, 1, 1'b0);
   endtask

   task automatic do_write(input int p, input int r, input logic [15:0] val, input logic [15:0] rel,
                           input int hold, input bit flip, input bit bad_start);
      logic lb;
      logic [15:0] v;
      preamble();
      if (bad_start) begin
         send_bit(1'b1, 1'b0, 1'b0, hold, flip);
         send_bit(1'b1, 1'b0, 1'b0, hold, flip);
      end
      send_field(4'b0101, 4, hold, flip);
      send_field(p, 5, hold, flip);
      send_field(r, 5, hold, flip);
      send_field(2'b10, 2, hold, flip);
      lb = 1'b0;
      for (int i = 15; i >= 0; i--) begin
         if (rel[i]) begin
            send_bit(1'b0, ~lb, 1'b0, hold, flip);
            v[i] = lb;
         end else begin
            send_bit(1'b1, val[i], 1'b0, hold, flip);
            v[i] = val[i];
         end
         lb = v[i];
      end
      m_mem[p][r] = v;
   endtask

   task automatic do_read(input int p, input int r, input string tag);
      preamble();
      send_field(4'b0110, 4, 1, 1'b0);
      send_field(p, 5, 1, 1'b0);
      send_field(r, 5, 1, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0, 1, 1'b0);
      exp_val.push_back(m_read(p, r));
      exp_tag.push_back(tag);
      for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b0, 1'b1, 1, 1'b0);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      check(1'b0, "watchdog expired", 16'h0, 16'h0);
      finish_run();
   end

   initial begin
      for (int p = 0; p < 32; p++)
         for (int r = 0; r < 32; r++) m_mem[p][r] = 16'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(dout == 1'b0, "R12 data-out after reset", {15'h0, dout}, 16'h0);

      // R5 R6 R7: write then read back, write has two turnaround bits, read one
      do_write(1, 4, 16'hA5C3, 16'h0, 1, 1'b0, 1'b0);
      check(dout == 1'b1, "R11 line bit after write", {15'h0, dout}, 16'h1);
      do_read(1, 4, "R7 R6 readback phy1 reg4");

      // R10: separate storage per PHY address
      do_write(2, 4, 16'h1234, 16'h0, 1, 1'b0, 1'b0);
      do_read(1, 4, "R10 phy1 reg4 untouched");
      do_read(2, 4, "R10 phy2 reg4");
      do_write(3, 12, 16'h0F0F, 16'h0, 1, 1'b0, 1'b0);
      do_read(3, 12, "R5 R10 phy3 reg12");
      do_read(24, 6, "R5 reversed address cell");

      // R8: control register masking
      do_write(5, 0, 16'hFFFF, 16'h0, 1, 1'b0, 1'b0);
      do_read(5, 0, "R8 reg0 all ones");
      do_write(5, 0, 16'h0000, 16'h0, 1, 1'b0, 1'b0);
      do_read(5, 0, "R8 reg0 all zeros");

      // R9: fixed words, also after writes to them
      do_write(6, 1, 16'h0000, 16'h0, 1, 1'b0, 1'b0);
      do_write(6, 17, 16'hFFFF, 16'h0, 1, 1'b0, 1'b0);
      do_read(6, 1,  "R9 R5 reg1 constant");
      do_read(6, 2,  "R9 reg2 constant");
      do_read(6, 3,  "R9 reg3 constant");
      do_read(6, 5,  "R9 reg5 constant");
      do_read(6, 6,  "R9 reg6 constant");
      do_read(6, 17, "R9 reg17 constant");
      do_read(0, 1,  "R5 R9 phy0 reg1 constant");

      // R1: long clock-high phases with data toggling while high
      do_write(9, 30, 16'h5A5A, 16'h0, 4, 1'b1, 1'b0);
      do_read(9, 30, "R1 long high phases");

      // R2: released bit times reuse the held line bit
      do_write(3, 8, 16'h8ABC, 16'h7000, 1, 1'b0, 1'b0);
      do_read(3, 8, "R2 released data bits");

      // R4: illegal opcodes followed by ones must not write phy31 reg31
      preamble();
      send_field(4'b0111, 4, 1, 1'b0);
      for (int i = 0; i < 30; i++) send_bit(1'b1, 1'b1, 1'b0, 1, 1'b0);
      do_read(31, 31, "R4 opcode 11 aborts");
      preamble();
      send_field(4'b0100, 4, 1, 1'b0);
      for (int i = 0; i < 30; i++) send_bit(1'b1, 1'b1, 1'b0, 1, 1'b0);
      do_read(31, 31, "R4 opcode 00 aborts");

      // R3: bad start bit, then a fresh frame right after the discard
      do_write(12, 9, 16'hC0DE, 16'h0, 1, 1'b0, 1'b1);
      do_read(12, 9, "R3 frame after bad start");

      // R11: line bit persists after the last read bit
      do_write(7, 7, 16'h0001, 16'h0, 1, 1'b0, 1'b0);
      do_read(7, 7, "R11 read value");
      repeat (5) @(negedge clk);
      check(dout == 1'b1, "R11 held last read bit", {15'h0, dout}, 16'h1);
      do_write(7, 8, 16'hFFFE, 16'h0, 1, 1'b0, 1'b0);
      do_read(7, 8, "R11 read even value");
      check(dout == 1'b0, "R11 held last zero bit", {15'h0, dout}, 16'h0);

      // R12: synchronous reset clears the array
      do_write(4, 4, 16'hBEEF, 16'h0, 1, 1'b0, 1'b0);
      check(dout == 1'b1, "R11 line bit after write", {15'h0, dout}, 16'h1);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(dout == 1'b0, "R12 data-out cleared", {15'h0, dout}, 16'h0);
      for (int p = 0; p < 32; p++)
         for (int r = 0; r < 32; r++) m_mem[p][r] = 16'h0;
      do_read(4, 4, "R12 array cleared");
      do_read(1, 4, "R12 array cleared phy1");

      repeat (4) @(negedge clk);
      check(exp_val.size() == 0, "scoreboard drained", 16'(exp_val.size()), 16'h0);
      finish_run();
   end

endmodule